// File: doc/BRIEF.md
# Double-Buffered PWM Output Channel

This block is one pulse-width-modulated output channel with a private up-counter. An external prescaler enable advances the counter by one per enabled clock. Each counter cycle starts at one and ends at the programmed period value, after which the counter returns to one. Two compare values shape the waveform. A leading-edge value drives the pin to its active level. A period value drives the pin back to its idle level and ends the cycle. The idle level is chosen by a polarity input.

Software writes the compare values into shadow registers through simple write strobes. The values only reach the active compare registers during a one-clock commit pulse. That pulse comes in the first clock in which the counter holds one. A write made at any point in one cycle therefore takes effect for the whole of the next cycle, and the waveform never tears. An update-hold input suppresses the commit, so a group of channels can be released together. A sticky match flag is set either by the period match alone or by either match, as selected. It is cleared by a write-one strobe.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After reset the counter reads 1, the output equals the polarity input (`idle_pol`), and the match flag is 0.
- R2: The counter changes only on clocks with `tick_en` high. On such a clock it becomes 1 if it equals the effective period value or its all-ones maximum; otherwise it increments by one. It never reads 0.
- R3: A commit happens in the first clock in which the counter holds 1 (right after reset, or after a wrap). It copies both shadow values into the active registers. The copied values already apply to match detection in that clock, and they apply for the rest of the cycle.
- R4: While `upd_hold` is 1 during a commit clock, the active registers keep their values. The shadow values wait for the next commit clock in which `upd_hold` is 0.
- R5: With `flag_sel` = 0, only a period match sets the flag. With `flag_sel` = 1, a leading-edge match or a period match sets it.
- R6: A leading-edge match drives `pwm_out` to the complement of `idle_pol`. A period match drives it to `idle_pol`. If both match in the same clock, the period match wins.
- R7: The flag stays set until a clock with `flag_clr` high. If a flag-setting match falls in that same clock, the flag stays 1.
- R8: A leading-edge value of 0 never matches, so `pwm_out` stays at the idle level for the whole cycle (0% duty).
- R9: Matches, commits and output changes happen only in the first clock after the counter takes a new value. This holds even when the counter dwells on a value for several clocks under a slow prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaler enable; counter advances when high |
| lead_wr | input | 1 | Write strobe for the leading-edge shadow register |
| lead_wdata | input | CNT_W | Leading-edge value to write |
| per_wr | input | 1 | Write strobe for the period shadow register |
| per_wdata | input | CNT_W | Period value to write |
| upd_hold | input | 1 | Suppress the shadow-to-active commit |
| flag_sel | input | 1 | 0: flag from period match; 1: flag from either match |
| idle_pol | input | 1 | Idle output level |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| cnt_o | output | CNT_W | Current counter value |
| pwm_out | output | 1 | PWM output pin |
| match_flag | output | 1 | Sticky match flag |

## Verification
Three pairs of functions can land in the same clock. A commit and a match share the clock where the counter enters 1. The two matches coincide when both compare values are equal. A flag set and a flag clear meet when the clear strobe is held high across match clocks. The bench provokes each pair with directed settings: a period of 1, equal leading-edge and period values, and a clear strobe held across several cycles. A cycle-level reference model of the requirements judges each case by predicting counter, pin and flag after every clock, and the scoreboard compares the prediction with the design's outputs.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    // Source selection for the sticky match flag
    typedef enum logic {
        FLG_PERIOD = 1'b0,
        FLG_EITHER = 1'b1
    } flag_src_e;

endpackage

// File: rtl/pwm_cnt.sv
// Channel counter: counts 1..period, marks the first clock of each new value
module pwm_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] per_eff,
    output logic [CNT_W-1:0] cnt,
    output logic             fresh
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fresh;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.fresh = tick_en;
        if (tick_en) begin
            if (st_q.cnt == per_eff || st_q.cnt == TOP) begin
                st_d.cnt = ONE;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= ONE;
            st_q.fresh <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign fresh = st_q.fresh;
endmodule

// File: rtl/pwm_regs.sv
// Shadow and active compare registers with gated commit
module pwm_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lead_wr,
    input  logic [CNT_W-1:0] lead_wdata,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             commit_req,
    input  logic             upd_hold,
    output logic [CNT_W-1:0] lead_eff,
    output logic [CNT_W-1:0] per_eff,
    output logic [CNT_W-1:0] lead_act,
    output logic [CNT_W-1:0] per_act
);
    typedef struct packed {
        logic [CNT_W-1:0] lead_sh;
        logic [CNT_W-1:0] per_sh;
        logic [CNT_W-1:0] lead_ac;
        logic [CNT_W-1:0] per_ac;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    commit;

    always_comb begin
        commit = commit_req && !upd_hold;
        st_d   = st_q;
        if (lead_wr) st_d.lead_sh = lead_wdata;
        if (per_wr)  st_d.per_sh  = per_wdata;
        if (commit) begin
            st_d.lead_ac = st_q.lead_sh;
            st_d.per_ac  = st_q.per_sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Values in force for this clock: committed data applies at once
    assign lead_eff = commit ? st_q.lead_sh : st_q.lead_ac;
    assign per_eff  = commit ? st_q.per_sh  : st_q.per_ac;
    assign lead_act = st_q.lead_ac;
    assign per_act  = st_q.per_ac;
endmodule

// File: rtl/pwm_match_out.sv
// Match detection, pin level and sticky flag
module pwm_match_out
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             fresh,
    input  logic [CNT_W-1:0] lead_eff,
    input  logic [CNT_W-1:0] per_eff,
    input  logic             idle_pol,
    input  flag_src_e        flag_src,
    input  logic             flag_clr,
    output logic             pwm_out,
    output logic             match_flag
);
    typedef struct packed {
        logic pin;
        logic flag;
    } out_st_t;

    out_st_t st_d, st_q;
    logic    hit_lead, hit_per, flag_set;

    always_comb begin
        hit_lead = fresh && (cnt == lead_eff);
        hit_per  = fresh && (cnt == per_eff);
        flag_set = hit_per || (flag_src == FLG_EITHER && hit_lead);
        st_d     = st_q;
        if (hit_per) begin
            st_d.pin = idle_pol;
        end else if (hit_lead) begin
            st_d.pin = ~idle_pol;
        end
        if (flag_set) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pin  <= idle_pol;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_out    = st_q.pin;
    assign match_flag = st_q.flag;
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             lead_wr,
    input  logic [CNT_W-1:0] lead_wdata,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             upd_hold,
    input  logic             flag_sel,
    input  logic             idle_pol,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_out,
    output logic             match_flag
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_val, lead_eff, per_eff, lead_act, per_act;
    logic             cnt_fresh, commit_req;
    flag_src_e        flag_src;

    assign commit_req = cnt_fresh && (cnt_val == ONE);
    assign flag_src   = flag_sel ? FLG_EITHER : FLG_PERIOD;

    pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .per_eff (per_eff),
        .cnt     (cnt_val),
        .fresh   (cnt_fresh)
    );

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .lead_wr    (lead_wr),
        .lead_wdata (lead_wdata),
        .per_wr     (per_wr),
        .per_wdata  (per_wdata),
        .commit_req (commit_req),
        .upd_hold   (upd_hold),
        .lead_eff   (lead_eff),
        .per_eff    (per_eff),
        .lead_act   (lead_act),
        .per_act    (per_act)
    );

    pwm_match_out #(.CNT_W(CNT_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt_val),
        .fresh      (cnt_fresh),
        .lead_eff   (lead_eff),
        .per_eff    (per_eff),
        .idle_pol   (idle_pol),
        .flag_src   (flag_src),
        .flag_clr   (flag_clr),
        .pwm_out    (pwm_out),
        .match_flag (match_flag)
    );

    assign cnt_o = cnt_val;
endmodule

// File: rtl/pwm_dbuf_chan_chk.sv
module pwm_dbuf_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             upd_hold,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cnt_o,
    input logic             pwm_out,
    input logic             match_flag,
    input logic             cnt_fresh,
    input logic [CNT_W-1:0] lead_act,
    input logic [CNT_W-1:0] per_act
);
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o != '0); // R2

    AST_CNT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(tick_en) |-> $stable(cnt_o)); // R2

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (per_act != '0) |-> (cnt_o <= per_act)); // R2

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(upd_hold) |-> $stable(lead_act) && $stable(per_act)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(match_flag) && !$past(flag_clr) |-> match_flag); // R7

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(cnt_fresh) |-> $stable(pwm_out)); // R9
endmodule

bind pwm_dbuf_chan pwm_dbuf_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .upd_hold   (upd_hold),
    .flag_clr   (flag_clr),
    .cnt_o      (cnt_o),
    .pwm_out    (pwm_out),
    .match_flag (match_flag),
    .cnt_fresh  (cnt_fresh),
    .lead_act   (lead_act),
    .per_act    (per_act)
);

// File: tb/sim_pwm_dbuf_chan.sv
`timescale 1ns/1ps
module sim_pwm_dbuf_chan;
    localparam int W = 8;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0, lead_wr = 1'b0, per_wr = 1'b0;
    logic [W-1:0] lead_wdata = '0, per_wdata = '0;
    logic         upd_hold = 1'b0, flag_sel = 1'b0, idle_pol = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] cnt_o;
    logic         pwm_out, match_flag;

    always #10 clk = ~clk;

    pwm_dbuf_chan #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .lead_wr(lead_wr), .lead_wdata(lead_wdata),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .upd_hold(upd_hold), .flag_sel(flag_sel), .idle_pol(idle_pol),
        .flag_clr(flag_clr), .cnt_o(cnt_o), .pwm_out(pwm_out),
        .match_flag(match_flag)
    );

    typedef struct {
        logic [W-1:0] cnt;
        logic         pin;
        logic         flag;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // Reference model state
    logic [W-1:0] m_cnt = 1, m_lsh = 0, m_psh = 0, m_lac = 0, m_pac = 0;
    logic         m_new = 1'b1, m_pin = 1'b0, m_flag = 1'b0;

    task automatic step(input logic tk, input logic lw, input logic [W-1:0] ld,
                        input logic pw, input logic [W-1:0] pd, input logic hold,
                        input logic fsel, input logic pol, input logic clr, input string tag);
        logic         commit, hl, hp;
        logic [W-1:0] le, pe;
        exp_t         e;
        @(negedge clk);
        tick_en = tk; lead_wr = lw; lead_wdata = ld; per_wr = pw; per_wdata = pd;
        upd_hold = hold; flag_sel = fsel; idle_pol = pol; flag_clr = clr;
        commit = m_new && (m_cnt == 1) && !hold;
        le = commit ? m_lsh : m_lac;
        pe = commit ? m_psh : m_pac;
        hl = m_new && (m_cnt == le);
        hp = m_new && (m_cnt == pe);
        if (hp) m_pin = pol;
        else if (hl) m_pin = ~pol;
        if (hp || (fsel && hl)) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        if (commit) begin m_lac = m_lsh; m_pac = m_psh; end
        if (lw) m_lsh = ld;
        if (pw) m_psh = pd;
        if (tk) m_cnt = (m_cnt == pe || m_cnt == MAXV) ? W'(1) : m_cnt + W'(1);
        m_new = tk;
        e.cnt = m_cnt; e.pin = m_pin; e.flag = m_flag; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Scoreboard monitor: compares after each edge, away from it
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (cnt_o !== e.cnt || pwm_out !== e.pin || match_flag !== e.flag) begin
                    n_bad++;
                    $display("FAIL %s: actual cnt=%0d pin=%b flag=%b expected cnt=%0d pin=%b flag=%b",
                             e.tag, cnt_o, pwm_out, match_flag, e.cnt, e.pin, e.flag);
                end
            end
        end
    end

    task automatic run(input int n, input logic tk, input logic hold, input logic fsel,
                       input logic pol, input logic clr, input string tag);
        for (int i = 0; i < n; i++) step(tk, 1'b0, '0, 1'b0, '0, hold, fsel, pol, clr, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_chk++;
        if (cnt_o !== W'(1) || pwm_out !== 1'b0 || match_flag !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: actual cnt=%0d pin=%b flag=%b expected cnt=1 pin=0 flag=0",
                     cnt_o, pwm_out, match_flag);
        end
        // R3: first commit takes zero shadows; counter runs to max, then new values apply
        step(1'b1, 1'b1, W'(3), 1'b1, W'(6), 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        run(262, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        run(20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        // R5: period-only flag, then either-match flag, with clears in between
        run(3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
        run(8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        run(3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
        run(12, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        // R7: clear held across matches; set wins over clear
        run(14, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
        run(6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        // R4: hold blocks the commit, release lets it through
        step(1'b1, 1'b1, W'(2), 1'b1, W'(4), 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        run(20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        run(16, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        // R8: leading value zero gives no active phase, inverted polarity
        step(1'b1, 1'b1, W'(0), 1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        run(16, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        // R6: equal leading and period values, period wins
        step(1'b1, 1'b1, W'(5), 1'b1, W'(5), 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        run(20, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        // R9: slow prescaler, one tick in three
        step(1'b1, 1'b1, W'(2), 1'b1, W'(3), 1'b0, 1'b1, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 45; i++)
            step((i % 3) == 0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, (i % 5) == 0, "R9");
        // R3: period of one, commit and period match in the same clock
        step(1'b1, 1'b1, W'(1), 1'b1, W'(1), 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        run(12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
        // R2: counter stalls with tick low
        run(6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        @(posedge clk);
        #6;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2: watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule